// File: doc/BRIEF.md
# Accumulator Pipeline Interlock Detector

This block guards a two-stage arithmetic pipeline that owns two accumulators and a status register. Each cycle it receives a short descriptor of the instruction that is trying to issue. The descriptor covers the accumulator that the arithmetic part writes, the accumulator and portion that the parallel move reads or writes, whether the status register is read, whether the scale/limit flags are updated, and whether the operation is a 24-bit logic operation. The block compares this descriptor with the two instructions issued before it. It then reports how many idle cycles must come first, which kinds of hazard are present, and a hold that freezes issue.

The design is combinational from the descriptor to the outputs and has no counter. While the hold is raised, the history advances with bubble entries that carry nothing. The reported count therefore falls by one in each held cycle and reaches zero in the cycle the waiting instruction issues. Instruction decoding and the datapath sit outside the block.

Top module: `acc_interlock`

## Requirements
- R1: An arithmetic instruction that writes an accumulator, followed by an arithmetic instruction with no move read, gives a count of 0 and no hazard kind.
- R2: A move read of any portion of the accumulator that the previous instruction's arithmetic part writes gives a count of 1 and sets hazard_kind bit 0. A read of the other accumulator gives 0.
- R3: A status read gives a count of 2 when the previous instruction updated the scale/limit flags. It gives 1 when only the instruction two slots back did. In both cases hazard_kind bit 1 is set.
- R4: A move read of an accumulator that the previous instruction's move wrote gives a count of 1 and sets hazard_kind bit 2. Any two portions of the same accumulator count as a match. A different accumulator gives 0.
- R5: A 24-bit logic operation whose own move writes the extension portion (part code 0) or the low portion (part code 2) of its own destination accumulator gives a count of 1 and sets hazard_kind bit 3. The high portion (code 1), the full accumulator (code 3) or another accumulator gives 0.
- R6: A move read of a full accumulator (part code 3) counts as a scale/limit flag update for later status reads.
- R7: While the count is non-zero, issue_hold is 1. With the descriptor held, the count drops by one in each cycle, because the inserted bubbles write nothing and update no flags. The instruction issues when the count reaches 0.
- R8: Reset clears the history, so the first instruction after reset sees no hazard.
- R9: When in_valid is 0, the outputs report no stall, and the slot enters the history as an empty entry.
- R10: When several hazard kinds apply, all of their bits are set and stall_cycles is the largest of their counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor holds a real instruction |
| alu_wr_en | input | 1 | Arithmetic part writes an accumulator |
| alu_wr_acc | input | ACC_IDX_W | Accumulator written by the arithmetic part |
| mv_rd_en | input | 1 | Move part reads an accumulator |
| mv_rd_acc | input | ACC_IDX_W | Accumulator read by the move |
| mv_rd_part | input | 2 | Portion read: 0 ext, 1 high, 2 low, 3 full |
| mv_wr_en | input | 1 | Move part writes an accumulator |
| mv_wr_acc | input | ACC_IDX_W | Accumulator written by the move |
| mv_wr_part | input | 2 | Portion written: 0 ext, 1 high, 2 low, 3 full |
| sr_rd | input | 1 | Instruction reads the status register |
| flag_upd | input | 1 | Instruction updates the scale/limit flags |
| logic24 | input | 1 | Instruction is a 24-bit logic operation |
| stall_cycles | output | 2 | Idle cycles still needed (0, 1 or 2) |
| issue_hold | output | 1 | Hold issue this cycle |
| hazard_kind | output | 4 | Bit 0 acc read after arithmetic write, bit 1 status, bit 2 move after move, bit 3 logic with own move |

## Verification
Each hazard kind is driven with a matching pair of instructions and again with a pair that differs only in the accumulator or the portion. This separates a correct match on the accumulator from a match on the portion. The status hazard is run at distance one and at distance two, and again with a full-accumulator read as the flag source, which tests the two-versus-one count and the implied flag update. Held descriptors are stepped cycle by cycle to confirm that the bubbles drain the count and that one cause is never counted twice. Idle slots, a reset in the middle of a run and a case with several hazards at once cover history clearing and the largest-count rule.

// File: rtl/acc_interlock_pkg.sv
package acc_interlock_pkg;

   localparam int ACC_IDX_MAX = 3;

   localparam int KIND_ACC_RD = 0;
   localparam int KIND_STATUS = 1;
   localparam int KIND_MOVE   = 2;
   localparam int KIND_LOGIC  = 3;
   localparam int KIND_N      = 4;

   typedef enum logic [1:0] {
      PART_EXT  = 2'd0,
      PART_HIGH = 2'd1,
      PART_LOW  = 2'd2,
      PART_FULL = 2'd3
   } acc_part_e;

   // one issued slot as remembered by the history
   typedef struct packed {
      logic                   alu_wr;
      logic [ACC_IDX_MAX-1:0] alu_acc;
      logic                   mv_wr;
      logic [ACC_IDX_MAX-1:0] mv_acc;
      logic                   flag_upd;
      logic                   stall_bub;
   } slot_t;

endpackage

// File: rtl/acc_interlock_hist.sv
module acc_interlock_hist
   import acc_interlock_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  hold,
   input  slot_t push_slot,
   output slot_t h1_q,
   output logic  h2_flag_q
);

   slot_t bubble;

   always_comb begin
      bubble           = '0;
      bubble.stall_bub = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h1_q      <= '0;
         h2_flag_q <= 1'b0;
      end else begin
         h2_flag_q <= h1_q.flag_upd;
         h1_q      <= hold ? bubble : push_slot;
      end
   end

   // R7: a held cycle leaves a bubble that writes nothing
   p_bubble_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (h1_q.stall_bub && !h1_q.alu_wr && !h1_q.mv_wr && !h1_q.flag_upd));

endmodule

// File: rtl/acc_interlock_cmp.sv
module acc_interlock_cmp
   import acc_interlock_pkg::*;
#(
   parameter bit LOGIC_CHECK = 1'b1
) (
   input  logic                   cur_valid,
   input  logic                   cur_alu_wr,
   input  logic [ACC_IDX_MAX-1:0] cur_alu_acc,
   input  logic                   cur_rd_en,
   input  logic [ACC_IDX_MAX-1:0] cur_rd_acc,
   input  logic                   cur_wr_en,
   input  logic [ACC_IDX_MAX-1:0] cur_wr_acc,
   input  logic [1:0]             cur_wr_part,
   input  logic                   cur_sr_rd,
   input  logic                   cur_logic24,
   input  slot_t                  prev1,
   input  logic                   prev2_flag,
   output logic [KIND_N-1:0]      kind,
   output logic [1:0]             need
);

   logic acc_rd_hit, sr_near, sr_far, mv_hit, logic_hit;

   assign acc_rd_hit = cur_valid && cur_rd_en && prev1.alu_wr &&
                       (prev1.alu_acc == cur_rd_acc);
   assign sr_near    = cur_valid && cur_sr_rd && prev1.flag_upd;
   assign sr_far     = cur_valid && cur_sr_rd && prev2_flag && !sr_near;
   assign mv_hit     = cur_valid && cur_rd_en && prev1.mv_wr &&
                       (prev1.mv_acc == cur_rd_acc);

   generate
      if (LOGIC_CHECK) begin : g_logic_chk
         // suppressed once the one idle slot has been spent
         assign logic_hit = cur_valid && cur_logic24 && cur_alu_wr && cur_wr_en &&
                            (cur_wr_acc == cur_alu_acc) && !prev1.stall_bub &&
                            (cur_wr_part == PART_EXT || cur_wr_part == PART_LOW);
      end else begin : g_logic_off
         assign logic_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      kind              = '0;
      kind[KIND_ACC_RD] = acc_rd_hit;
      kind[KIND_STATUS] = sr_near | sr_far;
      kind[KIND_MOVE]   = mv_hit;
      kind[KIND_LOGIC]  = logic_hit;
      if (sr_near)
         need = 2'd2;
      else if (sr_far || acc_rd_hit || mv_hit || logic_hit)
         need = 2'd1;
      else
         need = 2'd0;
   end

endmodule

// File: rtl/acc_interlock.sv
module acc_interlock
   import acc_interlock_pkg::*;
#(
   parameter int ACC_COUNT   = 2,
   parameter bit LOGIC_CHECK = 1'b1,
   localparam int ACC_IDX_W  = (ACC_COUNT > 1) ? $clog2(ACC_COUNT) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 alu_wr_en,
   input  logic [ACC_IDX_W-1:0] alu_wr_acc,
   input  logic                 mv_rd_en,
   input  logic [ACC_IDX_W-1:0] mv_rd_acc,
   input  logic [1:0]           mv_rd_part,
   input  logic                 mv_wr_en,
   input  logic [ACC_IDX_W-1:0] mv_wr_acc,
   input  logic [1:0]           mv_wr_part,
   input  logic                 sr_rd,
   input  logic                 flag_upd,
   input  logic                 logic24,
   output logic [1:0]           stall_cycles,
   output logic                 issue_hold,
   output logic [3:0]           hazard_kind
);

   generate
      if (ACC_COUNT < 2 || ACC_IDX_W > ACC_IDX_MAX) begin : g_bad_cfg
         $error("acc_interlock: ACC_COUNT out of range");
      end
   endgenerate

   logic [ACC_IDX_MAX-1:0] alu_acc_x, rd_acc_x, wr_acc_x;
   slot_t                  cur_slot, h1;
   logic                   h2_flag;
   logic [1:0]             need;
   logic [KIND_N-1:0]      kind;

   assign alu_acc_x = ACC_IDX_MAX'(alu_wr_acc);
   assign rd_acc_x  = ACC_IDX_MAX'(mv_rd_acc);
   assign wr_acc_x  = ACC_IDX_MAX'(mv_wr_acc);

   always_comb begin
      cur_slot           = '0;
      cur_slot.alu_wr    = in_valid & alu_wr_en;
      cur_slot.alu_acc   = alu_acc_x;
      cur_slot.mv_wr     = in_valid & mv_wr_en;
      cur_slot.mv_acc    = wr_acc_x;
      // R6: a full-accumulator read also moves the scale/limit flags
      cur_slot.flag_upd  = in_valid & (flag_upd | (mv_rd_en & (mv_rd_part == PART_FULL)));
      cur_slot.stall_bub = 1'b0;
   end

   acc_interlock_cmp #(.LOGIC_CHECK(LOGIC_CHECK)) u_cmp (
      .cur_valid   (in_valid),
      .cur_alu_wr  (alu_wr_en),
      .cur_alu_acc (alu_acc_x),
      .cur_rd_en   (mv_rd_en),
      .cur_rd_acc  (rd_acc_x),
      .cur_wr_en   (mv_wr_en),
      .cur_wr_acc  (wr_acc_x),
      .cur_wr_part (mv_wr_part),
      .cur_sr_rd   (sr_rd),
      .cur_logic24 (logic24),
      .prev1       (h1),
      .prev2_flag  (h2_flag),
      .kind        (kind),
      .need        (need)
   );

   acc_interlock_hist u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (issue_hold),
      .push_slot (cur_slot),
      .h1_q      (h1),
      .h2_flag_q (h2_flag)
   );

   assign stall_cycles = need;
   assign issue_hold   = (need != 2'd0);
   assign hazard_kind  = kind;

   p_acc_rd_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hazard_kind[KIND_ACC_RD] |=> !hazard_kind[KIND_ACC_RD]);

   p_status_far_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_cycles == 2'd2) |=> h2_flag);

   p_move_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hazard_kind[KIND_MOVE] |=> !hazard_kind[KIND_MOVE]);

   p_logic_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hazard_kind[KIND_LOGIC] |=> !hazard_kind[KIND_LOGIC]);

   p_full_read_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !issue_hold && mv_rd_en && mv_rd_part == PART_FULL) |=> h1.flag_upd);

endmodule

// File: tb/acc_interlock_bench.sv
module acc_interlock_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid, alu_wr_en, mv_rd_en, mv_wr_en, sr_rd, flag_upd, logic24;
   logic [0:0] alu_wr_acc, mv_rd_acc, mv_wr_acc;
   logic [1:0] mv_rd_part, mv_wr_part;
   logic [1:0] stall_cycles;
   logic       issue_hold;
   logic [3:0] hazard_kind;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   acc_interlock u_acc_interlock (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .alu_wr_en(alu_wr_en), .alu_wr_acc(alu_wr_acc),
      .mv_rd_en(mv_rd_en), .mv_rd_acc(mv_rd_acc), .mv_rd_part(mv_rd_part),
      .mv_wr_en(mv_wr_en), .mv_wr_acc(mv_wr_acc), .mv_wr_part(mv_wr_part),
      .sr_rd(sr_rd), .flag_upd(flag_upd), .logic24(logic24),
      .stall_cycles(stall_cycles), .issue_hold(issue_hold), .hazard_kind(hazard_kind)
   );

   // parts: 0 ext, 1 high, 2 low, 3 full
   task automatic drv(input bit v, input bit alu, input int aacc,
                      input bit rd, input int racc, input int rpart,
                      input bit wr, input int wacc, input int wpart,
                      input bit sr, input bit fu, input bit lg);
      in_valid   = v;
      alu_wr_en  = alu;  alu_wr_acc = 1'(aacc);
      mv_rd_en   = rd;   mv_rd_acc  = 1'(racc); mv_rd_part = 2'(rpart);
      mv_wr_en   = wr;   mv_wr_acc  = 1'(wacc); mv_wr_part = 2'(wpart);
      sr_rd      = sr;   flag_upd   = fu;       logic24    = lg;
   endtask

   task automatic idle();
      drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   // sample mid-cycle, then move to just after the next rising edge
   task automatic chk(input string req, input int exp_cyc, input logic [3:0] exp_kind);
      #3;
      checks++;
      if (stall_cycles != 2'(exp_cyc) || issue_hold != (exp_cyc != 0) || hazard_kind != exp_kind) begin
         errors++;
         $display("FAIL %s: stall=%0d hold=%0b kind=%b expected stall=%0d hold=%0b kind=%b",
                  req, stall_cycles, issue_hold, hazard_kind, exp_cyc, (exp_cyc != 0), exp_kind);
      end
      @(posedge clk); #1;
   endtask

   task automatic flush();
      idle(); chk("R9", 0, 4'b0000); chk("R9", 0, 4'b0000);
   endtask

   task automatic t_arith_chain();  // R1
      flush();
      drv(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk("R1", 0, 4'b0000);
      drv(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk("R1", 0, 4'b0000);
   endtask

   task automatic t_acc_read();  // R2, R7
      flush();
      drv(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk("R1", 0, 4'b0000);
      drv(1, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0); chk("R2", 1, 4'b0001);
      chk("R7", 0, 4'b0000);
      flush();
      drv(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk("R1", 0, 4'b0000);
      drv(1, 0, 0, 1, 0, 2, 0, 0, 0, 0, 0, 0); chk("R2", 0, 4'b0000);
   endtask

   task automatic t_status();  // R3, R6, R7
      flush();
      drv(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R3", 0, 4'b0000);
      drv(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0); chk("R3", 2, 4'b0010);
      chk("R7", 1, 4'b0010);
      chk("R7", 0, 4'b0000);
      flush();
      drv(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R3", 0, 4'b0000);
      drv(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk("R3", 0, 4'b0000);
      drv(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0); chk("R3", 1, 4'b0010);
      chk("R7", 0, 4'b0000);
      flush();
      drv(1, 0, 0, 1, 1, 3, 0, 0, 0, 0, 0, 0); chk("R6", 0, 4'b0000);
      drv(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0); chk("R6", 2, 4'b0010);
      chk("R6", 1, 4'b0010);
      chk("R6", 0, 4'b0000);
   endtask

   task automatic t_move();  // R4
      flush();
      drv(1, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0); chk("R4", 0, 4'b0000);
      drv(1, 0, 0, 1, 0, 2, 0, 0, 0, 0, 0, 0); chk("R4", 1, 4'b0100);
      chk("R4", 0, 4'b0000);
      flush();
      drv(1, 0, 0, 0, 0, 0, 1, 1, 3, 0, 0, 0); chk("R4", 0, 4'b0000);
      drv(1, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0); chk("R4", 0, 4'b0000);
   endtask

   task automatic t_logic();  // R5
      flush();
      drv(1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1); chk("R5", 1, 4'b1000);
      chk("R5", 0, 4'b0000);
      flush();
      drv(1, 1, 1, 0, 0, 0, 1, 1, 2, 0, 0, 1); chk("R5", 1, 4'b1000);
      chk("R5", 0, 4'b0000);
      flush();
      drv(1, 1, 0, 0, 0, 0, 1, 0, 1, 0, 0, 1); chk("R5", 0, 4'b0000);
      drv(1, 1, 0, 0, 0, 0, 1, 1, 2, 0, 0, 1); chk("R5", 0, 4'b0000);
   endtask

   task automatic t_idle_and_mix();  // R9, R10
      flush();
      drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R9", 0, 4'b0000);
      drv(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0); chk("R9", 0, 4'b0000);
      drv(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0); chk("R9", 0, 4'b0000);
      flush();
      drv(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R10", 0, 4'b0000);
      drv(1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0); chk("R10", 2, 4'b0011);
      chk("R10", 1, 4'b0010);
      chk("R10", 0, 4'b0000);
   endtask

   task automatic t_reset();  // R8
      flush();
      drv(1, 1, 0, 0, 0, 0, 1, 0, 3, 0, 1, 0);
      @(posedge clk); #1;
      rst_n = 1'b0; idle();
      @(posedge clk); #1;
      rst_n = 1'b1;
      drv(1, 0, 0, 1, 0, 3, 0, 0, 0, 1, 0, 0); chk("R8", 0, 4'b0000);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R8", 0, 4'b0000);
      t_arith_chain();
      t_acc_read();
      t_status();
      t_move();
      t_logic();
      t_idle_and_mix();
      t_reset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run incomplete, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule